// File: doc/BRIEF.md
# Per-Queue Packet-Count Notification Trigger

This block watches start-of-packet events on the two data directions of a 16-queue DMA engine: memory-to-stream (M2S) and stream-to-memory (S2M). Each queue and direction has its own enable, packet-count threshold and target software notification queue. When a queue reaches its programmed count, the block produces a notification record. The record holds the target software queue id, the source direction and a timestamp. It leaves the block on a valid/ready port.

A free-running timestamp advances each cycle by a programmable step. Each direction owns one holding slot for a record waiting on the output. While a stall enable is set, the matching stall output is raised whenever the notification sink is not ready or that direction's slot is still occupied. The upstream datapath uses this to pause packet flow. Software programs the block over an APB-style port. The port also holds a stored-only CRC seed per queue and direction.

Top module: `pkt_notify_trig`

## Requirements
- R1: After reset, every trigger register reads 0 and every software-queue field reads 0. Every CRC seed reads 0xFFFFFFFF, the stall-enable register reads 0x7, the timestamp step reads 0x400, and `ntf_vld` is low.
- R2: The per-queue register group for queue q sits at byte address q*0x20. M2S uses offsets 0x00 (trigger), 0x04 (CRC seed) and 0x08 (software queue). S2M uses 0x0C, 0x10 and 0x14 for the same three. The trigger holds the enable in bit 16 and the count in bits [15:0], and other bits read 0. The CRC seed is a full 32-bit store. The software-queue field is bits [3:0]. Global registers follow the queue groups: 0x200 is stall enables, 0x204 is the 24-bit timestamp step and 0x208 is the current timestamp (read only).
- R3: With the trigger enabled and a count of 0, every packet on that queue and direction produces one notification.
- R4: With the trigger enabled and a count N > 0, a notification is produced on the Nth packet. The counter then restarts, so the next one comes on packet 2N.
- R5: Packets on a queue and direction whose trigger is disabled produce no notification.
- R6: Any write to a trigger register clears that queue and direction's packet counter.
- R7: A record carries the software-queue field of its queue and direction. Its source is 0 for M2S and 1 for S2M.
- R8: When both directions hold a record, the M2S record is offered first. An offered record stays valid and unchanged until accepted.
- R9: Stall-enable bit 0 covers M2S packets, bit 1 covers S2M packets and bit 2 covers S2M completions. Each enabled output is high while `ntf_rdy` is low or while that direction's slot is occupied. A disabled output stays low.
- R10: The timestamp grows by the programmed step every cycle. A record carries the timestamp of the cycle in which its packet event was taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| apb_sel | input | 1 | Register port select |
| apb_enable | input | 1 | Register port access phase |
| apb_write | input | 1 | 1 = write, 0 = read |
| apb_addr | input | 12 | Byte address |
| apb_wdata | input | 32 | Write data |
| apb_rdata | output | 32 | Read data |
| apb_ready | output | 1 | Always ready |
| m2s_evt_vld | input | 1 | M2S start-of-packet event |
| m2s_evt_q | input | 4 | Queue of the M2S event |
| s2m_evt_vld | input | 1 | S2M start-of-packet event |
| s2m_evt_q | input | 4 | Queue of the S2M event |
| ntf_vld | output | 1 | Notification record valid |
| ntf_rdy | input | 1 | Notification sink ready |
| ntf_swq | output | 4 | Target software queue |
| ntf_src | output | 1 | Source: 0 = M2S, 1 = S2M |
| ntf_ts | output | 32 | Timestamp of the triggering packet |
| stall_m2s | output | 1 | Stall for M2S packets |
| stall_s2m | output | 1 | Stall for S2M packets |
| stall_s2m_cmpl | output | 1 | Stall for S2M completions |

## Verification
The bench covers the count boundaries: a count of 0, which must fire on every packet, and a count of 3. A design that compares before incrementing would fire one packet late there, or would never fire at 0. It rewrites a trigger partway through a count. A design that kept the old counter would then fire early. It raises M2S and S2M triggers in the same cycle with the sink not ready, to catch a design that offers S2M first, drops the second record or lets the offered record change while it waits. It also measures timestamp differences between records under two step values, which exposes an off-by-one capture cycle or a step that is ignored after a write.

// File: rtl/pnt_pkg.sv
package pnt_pkg;

   localparam int SWQ_W = 4;
   localparam int TS_W  = 32;

   typedef enum logic {
      SRC_M2S = 1'b0,
      SRC_S2M = 1'b1
   } ntf_src_e;

   typedef struct packed {
      logic [SWQ_W-1:0] swq;
      ntf_src_e         src;
      logic [TS_W-1:0]  ts;
   } ntf_rec_t;

   localparam int STALL_M2S_BIT  = 0;
   localparam int STALL_S2M_BIT  = 1;
   localparam int STALL_CMPL_BIT = 2;

endpackage

// File: rtl/pnt_regs.sv
module pnt_regs
   import pnt_pkg::*;
#(
   parameter int NQ      = 16,
   parameter int CNT_W   = 16,
   parameter int DELTA_W = 24,
   parameter int ADDR_W  = 12
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  apb_sel,
   input  logic                                  apb_enable,
   input  logic                                  apb_write,
   input  logic [ADDR_W-1:0]                     apb_addr,
   input  logic [31:0]                           apb_wdata,
   output logic [31:0]                           apb_rdata,
   input  logic [TS_W-1:0]                       ts_now,
   output logic [1:0][NQ-1:0]                    trig_en,
   output logic [1:0][NQ-1:0][CNT_W-1:0]         trig_thr,
   output logic [1:0][NQ-1:0][SWQ_W-1:0]         trig_swq,
   output logic [1:0][NQ-1:0]                    trig_wr,
   output logic [2:0]                            stall_en,
   output logic [DELTA_W-1:0]                    ts_delta
);

   localparam int QW = $clog2(NQ);
   localparam logic [ADDR_W-1:0]  GLB_ADDR  = ADDR_W'(NQ * 32);
   localparam logic [DELTA_W-1:0] DELTA_RST = DELTA_W'(24'h400);

   logic [1:0][NQ-1:0]            en_q;
   logic [1:0][NQ-1:0][CNT_W-1:0] thr_q;
   logic [1:0][NQ-1:0][SWQ_W-1:0] swq_q;
   logic [1:0][NQ-1:0][31:0]      crc_q;
   logic [2:0]                    stall_q;
   logic [DELTA_W-1:0]            delta_q;

   logic          aligned, in_q, glb_hit, wr_en, dsel;
   logic [QW-1:0] qi;
   logic [2:0]    ri, sub;

   assign aligned = (apb_addr[1:0] == 2'b00);
   assign in_q    = aligned && (apb_addr < GLB_ADDR);
   assign glb_hit = aligned && (apb_addr[ADDR_W-1:5] == GLB_ADDR[ADDR_W-1:5]);
   assign qi      = apb_addr[QW+4:5];
   assign ri      = apb_addr[4:2];
   assign dsel    = (ri >= 3'd3);
   assign sub     = dsel ? (ri - 3'd3) : ri;
   assign wr_en   = apb_sel && apb_enable && apb_write;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= '0;
         thr_q   <= '0;
         swq_q   <= '0;
         crc_q   <= '1;
         stall_q <= 3'b111;
         delta_q <= DELTA_RST;
      end else if (wr_en) begin
         if (in_q) begin
            case (sub)
               3'd0: begin
                  en_q[dsel][qi]  <= apb_wdata[16];
                  thr_q[dsel][qi] <= apb_wdata[CNT_W-1:0];
               end
               3'd1:    crc_q[dsel][qi] <= apb_wdata;
               3'd2:    swq_q[dsel][qi] <= apb_wdata[SWQ_W-1:0];
               default: ;
            endcase
         end else if (glb_hit) begin
            case (ri)
               3'd0:    stall_q <= apb_wdata[2:0];
               3'd1:    delta_q <= apb_wdata[DELTA_W-1:0];
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      for (int d = 0; d < 2; d++) begin
         for (int q = 0; q < NQ; q++) begin
            trig_wr[d][q] = wr_en && in_q && (sub == 3'd0) &&
                            (dsel == 1'(d)) && (qi == QW'(q));
         end
      end
   end

   always_comb begin
      apb_rdata = '0;
      if (in_q) begin
         case (sub)
            3'd0: begin
               apb_rdata[16]        = en_q[dsel][qi];
               apb_rdata[CNT_W-1:0] = thr_q[dsel][qi];
            end
            3'd1:    apb_rdata = crc_q[dsel][qi];
            3'd2:    apb_rdata[SWQ_W-1:0] = swq_q[dsel][qi];
            default: ;
         endcase
      end else if (glb_hit) begin
         case (ri)
            3'd0:    apb_rdata[2:0] = stall_q;
            3'd1:    apb_rdata[DELTA_W-1:0] = delta_q;
            3'd2:    apb_rdata = ts_now;
            default: ;
         endcase
      end
   end

   assign trig_en  = en_q;
   assign trig_thr = thr_q;
   assign trig_swq = swq_q;
   assign stall_en = stall_q;
   assign ts_delta = delta_q;

endmodule

// File: rtl/pnt_qcount.sv
module pnt_qcount
   import pnt_pkg::*;
#(
   parameter int NQ    = 16,
   parameter int CNT_W = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          evt_vld,
   input  logic [$clog2(NQ)-1:0]         evt_q,
   input  logic [NQ-1:0]                 trig_en,
   input  logic [NQ-1:0][CNT_W-1:0]      trig_thr,
   input  logic [NQ-1:0]                 trig_wr,
   input  logic [NQ-1:0][SWQ_W-1:0]      trig_swq,
   output logic                          fire,
   output logic [SWQ_W-1:0]              fire_swq
);

   localparam int QW = $clog2(NQ);

   logic [CNT_W-1:0] cnt_q [NQ];
   logic             hit;
   logic [CNT_W:0]   nxt;
   logic [CNT_W-1:0] thr_sel;

   assign thr_sel  = trig_thr[evt_q];
   assign hit      = evt_vld && trig_en[evt_q];
   assign nxt      = {1'b0, cnt_q[evt_q]} + (CNT_W+1)'(1);
   assign fire     = hit && ((thr_sel == '0) || (nxt == {1'b0, thr_sel}));
   assign fire_swq = trig_swq[evt_q];

   for (genvar q = 0; q < NQ; q++) begin : g_cnt
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q[q] <= '0;
         end else if (trig_wr[q]) begin
            cnt_q[q] <= '0;
         end else if (hit && (evt_q == QW'(q))) begin
            cnt_q[q] <= fire ? '0 : nxt[CNT_W-1:0];
         end
      end

      AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
         (trig_thr[q] == '0) ? (cnt_q[q] == '0) : (cnt_q[q] < trig_thr[q])); // R4

      AST_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         trig_wr[q] |=> (cnt_q[q] == '0)); // R6
   end

endmodule

// File: rtl/pnt_ntf_out.sv
module pnt_ntf_out
   import pnt_pkg::*;
#(
   parameter int DELTA_W = 24
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [1:0]                  fire,
   input  logic [1:0][SWQ_W-1:0]       fire_swq,
   input  logic [DELTA_W-1:0]          ts_delta,
   input  logic [2:0]                  stall_en,
   input  logic                        ntf_rdy,
   output logic                        ntf_vld,
   output ntf_rec_t                    ntf_rec,
   output logic [TS_W-1:0]             ts_now,
   output logic                        stall_m2s,
   output logic                        stall_s2m,
   output logic                        stall_cmpl
);

   logic [1:0]      pend_q;
   ntf_rec_t        slot_q [2];
   logic            held_q, held_sel_q, sel, accept;
   logic [1:0]      drain;
   logic [TS_W-1:0] ts_q;

   assign sel    = held_q ? held_sel_q : ~pend_q[0];
   assign accept = ntf_vld && ntf_rdy;

   always_comb begin
      drain[0] = accept && !sel;
      drain[1] = accept && sel;
   end

   for (genvar d = 0; d < 2; d++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend_q[d] <= 1'b0;
            slot_q[d] <= '0;
         end else if (fire[d] && (!pend_q[d] || drain[d])) begin
            pend_q[d]     <= 1'b1;
            slot_q[d].swq <= fire_swq[d];
            slot_q[d].src <= (d == 0) ? SRC_M2S : SRC_S2M;
            slot_q[d].ts  <= ts_q;
         end else if (drain[d]) begin
            pend_q[d] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q     <= 1'b0;
         held_sel_q <= 1'b0;
         ts_q       <= '0;
      end else begin
         held_q     <= ntf_vld && !ntf_rdy;
         held_sel_q <= sel;
         ts_q       <= ts_q + TS_W'(ts_delta);
      end
   end

   assign ntf_vld    = |pend_q;
   assign ntf_rec    = sel ? slot_q[1] : slot_q[0];
   assign ts_now     = ts_q;
   assign stall_m2s  = stall_en[STALL_M2S_BIT]  && (!ntf_rdy || pend_q[0]);
   assign stall_s2m  = stall_en[STALL_S2M_BIT]  && (!ntf_rdy || pend_q[1]);
   assign stall_cmpl = stall_en[STALL_CMPL_BIT] && (!ntf_rdy || pend_q[1]);

   AST_HOLD_REC: assert property (@(posedge clk) disable iff (!rst_n)
      (ntf_vld && !ntf_rdy) |=> (ntf_vld && $stable(ntf_rec))); // R8

   AST_M2S_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[0] && !held_q) |-> (ntf_rec.src == SRC_M2S)); // R8

   AST_STALL_M2S: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_en[STALL_M2S_BIT] && !ntf_rdy) |-> stall_m2s); // R9

   AST_STALL_CMPL: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_en[STALL_CMPL_BIT] && !ntf_rdy) |-> stall_cmpl); // R9

   AST_TS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (ts_q == $past(ts_q) + TS_W'($past(ts_delta)))); // R10

endmodule

// File: rtl/pkt_notify_trig.sv
module pkt_notify_trig
   import pnt_pkg::*;
#(
   parameter int NQ      = 16,
   parameter int CNT_W   = 16,
   parameter int DELTA_W = 24,
   parameter int ADDR_W  = 12
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    apb_sel,
   input  logic                    apb_enable,
   input  logic                    apb_write,
   input  logic [ADDR_W-1:0]       apb_addr,
   input  logic [31:0]             apb_wdata,
   output logic [31:0]             apb_rdata,
   output logic                    apb_ready,
   input  logic                    m2s_evt_vld,
   input  logic [$clog2(NQ)-1:0]   m2s_evt_q,
   input  logic                    s2m_evt_vld,
   input  logic [$clog2(NQ)-1:0]   s2m_evt_q,
   output logic                    ntf_vld,
   input  logic                    ntf_rdy,
   output logic [SWQ_W-1:0]        ntf_swq,
   output logic                    ntf_src,
   output logic [TS_W-1:0]         ntf_ts,
   output logic                    stall_m2s,
   output logic                    stall_s2m,
   output logic                    stall_s2m_cmpl
);

   localparam int QW = $clog2(NQ);

   if (NQ < 2 || (1 << QW) != NQ) begin : g_bad_nq
      $error("NQ must be a power of two and at least 2");
   end
   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
      $error("CNT_W must be 1..16");
   end
   if (DELTA_W < 1 || DELTA_W > TS_W) begin : g_bad_delta
      $error("DELTA_W must be 1..TS_W");
   end
   if (NQ * 32 + 32 > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too small for the register map");
   end

   logic [1:0][NQ-1:0]            trig_en, trig_wr;
   logic [1:0][NQ-1:0][CNT_W-1:0] trig_thr;
   logic [1:0][NQ-1:0][SWQ_W-1:0] trig_swq;
   logic [2:0]                    stall_en;
   logic [DELTA_W-1:0]            ts_delta;
   logic [TS_W-1:0]               ts_now;
   logic [1:0]                    evt_vld, fire;
   logic [1:0][QW-1:0]            evt_q;
   logic [1:0][SWQ_W-1:0]         fire_swq;
   ntf_rec_t                      rec;

   assign evt_vld = {s2m_evt_vld, m2s_evt_vld};
   assign evt_q   = {s2m_evt_q, m2s_evt_q};

   pnt_regs #(.NQ(NQ), .CNT_W(CNT_W), .DELTA_W(DELTA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .apb_sel    (apb_sel),
      .apb_enable (apb_enable),
      .apb_write  (apb_write),
      .apb_addr   (apb_addr),
      .apb_wdata  (apb_wdata),
      .apb_rdata  (apb_rdata),
      .ts_now     (ts_now),
      .trig_en    (trig_en),
      .trig_thr   (trig_thr),
      .trig_swq   (trig_swq),
      .trig_wr    (trig_wr),
      .stall_en   (stall_en),
      .ts_delta   (ts_delta)
   );

   for (genvar d = 0; d < 2; d++) begin : g_dir
      pnt_qcount #(.NQ(NQ), .CNT_W(CNT_W)) u_cnt (
         .clk      (clk),
         .rst_n    (rst_n),
         .evt_vld  (evt_vld[d]),
         .evt_q    (evt_q[d]),
         .trig_en  (trig_en[d]),
         .trig_thr (trig_thr[d]),
         .trig_wr  (trig_wr[d]),
         .trig_swq (trig_swq[d]),
         .fire     (fire[d]),
         .fire_swq (fire_swq[d])
      );
   end

   pnt_ntf_out #(.DELTA_W(DELTA_W)) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .fire       (fire),
      .fire_swq   (fire_swq),
      .ts_delta   (ts_delta),
      .stall_en   (stall_en),
      .ntf_rdy    (ntf_rdy),
      .ntf_vld    (ntf_vld),
      .ntf_rec    (rec),
      .ts_now     (ts_now),
      .stall_m2s  (stall_m2s),
      .stall_s2m  (stall_s2m),
      .stall_cmpl (stall_s2m_cmpl)
   );

   assign ntf_swq   = rec.swq;
   assign ntf_src   = rec.src;
   assign ntf_ts    = rec.ts;
   assign apb_ready = 1'b1;

endmodule

// File: tb/pkt_notify_trig_tb.sv
module pkt_notify_trig_tb;
   import pnt_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        apb_sel = 1'b0, apb_enable = 1'b0, apb_write = 1'b0;
   logic [11:0] apb_addr = '0;
   logic [31:0] apb_wdata = '0;
   logic [31:0] apb_rdata;
   logic        apb_ready;
   logic        m2s_evt_vld = 1'b0, s2m_evt_vld = 1'b0;
   logic [3:0]  m2s_evt_q = '0, s2m_evt_q = '0;
   logic        ntf_vld, ntf_rdy = 1'b1, ntf_src;
   logic [3:0]  ntf_swq;
   logic [31:0] ntf_ts;
   logic        stall_m2s, stall_s2m, stall_s2m_cmpl;

   int n_chk = 0;
   int n_err = 0;
   ntf_rec_t mon_q[$];

   always #2 clk = ~clk;

   pkt_notify_trig u_dut (
      .clk(clk), .rst_n(rst_n),
      .apb_sel(apb_sel), .apb_enable(apb_enable), .apb_write(apb_write),
      .apb_addr(apb_addr), .apb_wdata(apb_wdata), .apb_rdata(apb_rdata),
      .apb_ready(apb_ready),
      .m2s_evt_vld(m2s_evt_vld), .m2s_evt_q(m2s_evt_q),
      .s2m_evt_vld(s2m_evt_vld), .s2m_evt_q(s2m_evt_q),
      .ntf_vld(ntf_vld), .ntf_rdy(ntf_rdy), .ntf_swq(ntf_swq),
      .ntf_src(ntf_src), .ntf_ts(ntf_ts),
      .stall_m2s(stall_m2s), .stall_s2m(stall_s2m), .stall_s2m_cmpl(stall_s2m_cmpl)
   );

   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (rst_n && ntf_vld && ntf_rdy) begin
            ntf_rec_t r;
            r.swq = ntf_swq;
            r.src = ntf_src ? SRC_S2M : SRC_M2S;
            r.ts  = ntf_ts;
            mon_q.push_back(r);
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [11:0] a_trig(input int q, input int d);
      return 12'(q * 32 + d * 12);
   endfunction

   task automatic apb_wr(input logic [11:0] a, input logic [31:0] v);
      @(negedge clk);
      apb_sel = 1'b1; apb_write = 1'b1; apb_addr = a; apb_wdata = v; apb_enable = 1'b0;
      @(negedge clk);
      apb_enable = 1'b1;
      @(negedge clk);
      apb_sel = 1'b0; apb_enable = 1'b0; apb_write = 1'b0;
   endtask

   task automatic apb_rd(input logic [11:0] a, output logic [31:0] v);
      @(negedge clk);
      apb_sel = 1'b1; apb_write = 1'b0; apb_addr = a; apb_enable = 1'b0;
      @(negedge clk);
      apb_enable = 1'b1;
      #1 v = apb_rdata;
      @(negedge clk);
      apb_sel = 1'b0; apb_enable = 1'b0;
   endtask

   task automatic send_evt(input int d, input int q);
      @(negedge clk);
      if (d == 0) begin m2s_evt_vld = 1'b1; m2s_evt_q = 4'(q); end
      else        begin s2m_evt_vld = 1'b1; s2m_evt_q = 4'(q); end
      @(negedge clk);
      m2s_evt_vld = 1'b0; s2m_evt_vld = 1'b0;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
      #2;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      chk("R1 ntf_vld", 32'(ntf_vld), 32'h0);
      apb_rd(a_trig(0, 0), v);      chk("R1 trigger", v, 32'h0);
      apb_rd(a_trig(15, 1) + 4, v); chk("R1 crc seed", v, 32'hFFFF_FFFF);
      apb_rd(a_trig(6, 0) + 8, v);  chk("R1 swq", v, 32'h0);
      apb_rd(12'h200, v);           chk("R1 stall cfg", v, 32'h7);
      apb_rd(12'h204, v);           chk("R1 ts step", v, 32'h400);
      chk("R1 stall_m2s idle", 32'(stall_m2s), 32'h0);
   endtask

   task automatic t_regs();
      logic [31:0] v;
      apb_wr(a_trig(4, 0) + 4, 32'h1234_5678);
      apb_rd(a_trig(4, 0) + 4, v);  chk("R2 crc store", v, 32'h1234_5678);
      apb_wr(a_trig(4, 1) + 8, 32'h13);
      apb_rd(a_trig(4, 1) + 8, v);  chk("R2 swq 4 bits", v, 32'h3);
      apb_wr(a_trig(4, 1), 32'hFFFF_FFFF);
      apb_rd(a_trig(4, 1), v);      chk("R2 trigger fields", v, 32'h0001_FFFF);
      apb_rd(a_trig(4, 0), v);      chk("R2 m2s untouched", v, 32'h0);
      apb_wr(a_trig(4, 1), 32'h0);
   endtask

   task automatic t_every();
      int n0;
      apb_wr(a_trig(2, 0), 32'h0001_0000);
      apb_wr(a_trig(2, 0) + 8, 32'h9);
      n0 = mon_q.size();
      for (int i = 0; i < 3; i++) send_evt(0, 2);
      settle();
      chk("R3 count 0 every packet", 32'(mon_q.size() - n0), 32'd3);
      chk("R7 swq m2s", 32'(mon_q[mon_q.size()-1].swq), 32'h9);
      chk("R7 src m2s", 32'(mon_q[mon_q.size()-1].src), 32'h0);
   endtask

   task automatic t_thresh();
      int n0;
      apb_wr(a_trig(5, 1), 32'h0001_0003);
      apb_wr(a_trig(5, 1) + 8, 32'h4);
      n0 = mon_q.size();
      send_evt(1, 5); send_evt(1, 5);
      settle();
      chk("R4 before Nth", 32'(mon_q.size() - n0), 32'd0);
      send_evt(1, 5);
      settle();
      chk("R4 at Nth", 32'(mon_q.size() - n0), 32'd1);
      chk("R7 swq s2m", 32'(mon_q[mon_q.size()-1].swq), 32'h4);
      chk("R7 src s2m", 32'(mon_q[mon_q.size()-1].src), 32'h1);
      for (int i = 0; i < 3; i++) send_evt(1, 5);
      send_evt(1, 5);
      settle();
      chk("R4 at 2N then restart", 32'(mon_q.size() - n0), 32'd2);
   endtask

   task automatic t_disabled();
      int n0;
      apb_wr(a_trig(7, 0), 32'h0000_0000);
      n0 = mon_q.size();
      for (int i = 0; i < 5; i++) send_evt(0, 7);
      settle();
      chk("R5 disabled no notify", 32'(mon_q.size() - n0), 32'd0);
      chk("R5 ntf_vld low", 32'(ntf_vld), 32'h0);
   endtask

   task automatic t_wrclr();
      int n0;
      apb_wr(a_trig(3, 0), 32'h0001_0003);
      n0 = mon_q.size();
      send_evt(0, 3); send_evt(0, 3);
      apb_wr(a_trig(3, 0), 32'h0001_0003);
      send_evt(0, 3); send_evt(0, 3);
      settle();
      chk("R6 counter cleared by write", 32'(mon_q.size() - n0), 32'd0);
      send_evt(0, 3);
      settle();
      chk("R6 fires after full count", 32'(mon_q.size() - n0), 32'd1);
   endtask

   task automatic t_arb();
      int n0;
      apb_wr(a_trig(1, 0), 32'h0001_0000);
      apb_wr(a_trig(1, 0) + 8, 32'h1);
      apb_wr(a_trig(1, 1), 32'h0001_0000);
      apb_wr(a_trig(1, 1) + 8, 32'h2);
      n0 = mon_q.size();
      @(negedge clk);
      ntf_rdy = 1'b0;
      @(negedge clk);
      m2s_evt_vld = 1'b1; m2s_evt_q = 4'd1;
      s2m_evt_vld = 1'b1; s2m_evt_q = 4'd1;
      @(negedge clk);
      m2s_evt_vld = 1'b0; s2m_evt_vld = 1'b0;
      repeat (2) @(negedge clk);
      #1;
      chk("R8 vld while held", 32'(ntf_vld), 32'h1);
      chk("R8 m2s offered first src", 32'(ntf_src), 32'h0);
      chk("R8 m2s offered first swq", 32'(ntf_swq), 32'h1);
      chk("R9 stall_m2s", 32'(stall_m2s), 32'h1);
      chk("R9 stall_s2m", 32'(stall_s2m), 32'h1);
      chk("R9 stall_s2m_cmpl", 32'(stall_s2m_cmpl), 32'h1);
      repeat (3) @(negedge clk);
      #1;
      chk("R8 record held swq", 32'(ntf_swq), 32'h1);
      @(negedge clk);
      ntf_rdy = 1'b1;
      settle();
      chk("R8 both delivered", 32'(mon_q.size() - n0), 32'd2);
      chk("R8 first is m2s", 32'(mon_q[n0].src), 32'h0);
      chk("R8 first swq", 32'(mon_q[n0].swq), 32'h1);
      chk("R8 second is s2m", 32'(mon_q[n0+1].src), 32'h1);
      chk("R8 second swq", 32'(mon_q[n0+1].swq), 32'h2);
   endtask

   task automatic t_stallcfg();
      apb_wr(12'h200, 32'h2);
      @(negedge clk);
      ntf_rdy = 1'b0;
      #1;
      chk("R9 m2s stall disabled", 32'(stall_m2s), 32'h0);
      chk("R9 s2m stall enabled", 32'(stall_s2m), 32'h1);
      chk("R9 cmpl stall disabled", 32'(stall_s2m_cmpl), 32'h0);
      @(negedge clk);
      ntf_rdy = 1'b1;
      #1;
      chk("R9 s2m stall released", 32'(stall_s2m), 32'h0);
      apb_wr(12'h200, 32'h7);
   endtask

   task automatic t_ts();
      logic [31:0] t1, t2, v1, v2;
      apb_wr(a_trig(0, 0), 32'h0001_0000);
      send_evt(0, 0);
      repeat (6) @(negedge clk);
      send_evt(0, 0);
      settle();
      t1 = mon_q[mon_q.size()-2].ts;
      t2 = mon_q[mon_q.size()-1].ts;
      chk("R10 ts diff default step", t2 - t1, 32'(8 * 32'h400));
      apb_wr(12'h204, 32'h10);
      send_evt(0, 0);
      repeat (3) @(negedge clk);
      send_evt(0, 0);
      settle();
      t1 = mon_q[mon_q.size()-2].ts;
      t2 = mon_q[mon_q.size()-1].ts;
      chk("R10 ts diff new step", t2 - t1, 32'(5 * 32'h10));
      apb_rd(12'h208, v1);
      apb_rd(12'h208, v2);
      chk("R10 ts register advances", v2 - v1, 32'(3 * 32'h10));
      apb_wr(12'h204, 32'h400);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_every();
      t_thresh();
      t_disabled();
      t_wrclr();
      t_arb();
      t_stallcfg();
      t_ts();
      summary();
      $finish;
   end

endmodule